// File: doc/BRIEF.md
# Transactional Address Signature Snoop Unit

This unit keeps two hashed address signatures for one processor that runs transactions whose write data is buffered in software. One signature records the word addresses the transaction has read, the other the word addresses it intends to write. Each signature is a bit vector. An address is entered by setting the bits chosen by several independent hash functions of that address. An address counts as present only when all of its bits are set. An address that was entered is therefore always reported present. A foreign address may also be reported present, which is a harmless false positive.

The processor steers the unit with a 3-bit command: start a transaction, enter a read or write address, enter the commit phase, report that exclusive ownership of the whole write set has been obtained, report that write-back is finished, or abort. Incoming coherence requests are checked against the signatures according to the current phase. A hit either raises a one-cycle conflict pulse, and the unit aborts the transaction by itself, or it produces a NACK for that request once the transaction has been validated. A separate query port tells software within one cycle whether an address may be in the write set, so software can skip its write-buffer search when the answer is no.

Top module: `txsig_snoop_unit`

## Requirements
- R1: After a synchronous active-high reset, the unit is idle, both signatures are empty, and conflict_o, nack_o and wq_hit_o are 0, even if reset arrives in the middle of a commit.
- R2: A read address entered during the active phase makes a later exclusive snoop (snp_excl=1) to that address raise conflict_o in the cycle after the snoop. An entered address never misses.
- R3: Shared snoops (snp_excl=0) never raise a conflict in the active phase, even when they hit the read signature. While idle, snoops have no effect.
- R4: A write address entered during the active phase makes wq_hit_o equal 1 in the cycle after a query for it. A query against an empty write signature returns 0.
- R5: A snoop conflict clears both signatures and returns the unit to idle at the same edge that raises conflict_o. Later snoops and queries see empty signatures. A command given in the same cycle as a conflict is dropped.
- R6: In the commit phase before validation, any snoop that hits the write signature raises conflict_o, whether shared or exclusive. Exclusive snoops that hit the read signature still conflict. In the active phase, hits on the write signature are ignored.
- R7: After validation, snoops that hit the write signature get nack_o=1 in the next cycle and never raise conflict_o. The read signature is cleared at validation.
- R8: The write-back-done command in the validated phase clears the write signature, ends NACKing and returns the unit to idle.
- R9: An abort command in the active or commit phase clears both signatures and returns the unit to idle without a conflict pulse. In the validated phase, abort is ignored.
- R10: cmd_op codes: 0 none, 1 begin, 2 enter read address, 3 enter write address, 4 enter commit, 5 validated, 6 write-back done, 7 abort. Begin is accepted only when idle. Address entries and commit are accepted only in the active phase. Validated is accepted only in commit, and done only in the validated phase. Any other combination is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Processor command code (see R10) |
| cmd_addr | input | ADDR_W | Word address for address-entry commands |
| snp_valid | input | 1 | A coherence request is present this cycle |
| snp_excl | input | 1 | 1 = exclusive request, 0 = shared request |
| snp_addr | input | ADDR_W | Word address of the coherence request |
| wq_valid | input | 1 | Write-signature query present |
| wq_addr | input | ADDR_W | Word address to query |
| conflict_o | output | 1 | One-cycle pulse: transaction aborted by a snoop hit |
| nack_o | output | 1 | Previous cycle's snoop is refused (validated phase) |
| wq_hit_o | output | 1 | Previous cycle's query address may be in the write set |

## Verification
A lost signature bit shows up as a false negative: an exclusive snoop to an address that was read, or a query for an address that was written, returns 0 one cycle after the request. A phase register stuck in the wrong state shows up as the wrong response to the very next snoop. Examples are a conflict pulse on a shared request during the active phase, a conflict instead of a NACK after validation, or a NACK that persists after write-back is done. A clear that is missing or comes late leaves stale bits, so the first query or snoop after an abort, a conflict, validation or write-back completion reports a hit where it should report a miss.

// File: rtl/txsig_pkg.sv
package txsig_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_BEGIN  = 3'd1,
    OP_RD_INS = 3'd2,
    OP_WR_INS = 3'd3,
    OP_COMMIT = 3'd4,
    OP_VALID  = 3'd5,
    OP_DONE   = 3'd6,
    OP_ABORT  = 3'd7
  } txsig_op_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACTIVE = 2'd1,
    PH_COMMIT = 2'd2,
    PH_VALID  = 2'd3
  } txsig_phase_e;

endpackage

// File: rtl/txsig_hash.sv
module txsig_hash #(
  parameter int AW   = 32,
  parameter int IW   = 10,
  parameter int SEED = 1
) (
  input  logic [AW-1:0] addr_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [63:0] KEY  = 64'h9E37_79B9_7F4A_7C15 ^ (64'(SEED) * 64'hC2B2_AE3D_27D4_EB4F);
  localparam logic [AW-1:0] MULT = KEY[AW-1:0] | AW'(1);
  localparam int SH    = AW - IW;
  localparam int FOLD  = AW / 2;

  logic [AW-1:0] mixed;

  // Fold the high half in so low-entropy upper bits still move the index.
  assign mixed = addr_i ^ (addr_i >> FOLD);
  assign idx_o = IW'((mixed * MULT) >> SH);
endmodule

// File: rtl/txsig_sigvec.sv
module txsig_sigvec #(
  parameter int SB = 1024,
  parameter int NH = 2,
  parameter int IW = $clog2(SB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             ins_i,
  input  logic [NH*IW-1:0] ins_idx_i,
  output logic [SB-1:0]    bits_o
);
  logic [SB-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    for (int h = 0; h < NH; h++) begin
      set_mask[ins_idx_i[h*IW +: IW]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      bits_o <= '0;
    end else if (ins_i) begin
      bits_o <= bits_o | set_mask;
    end
  end
endmodule

// File: rtl/txsig_member.sv
module txsig_member #(
  parameter int SB = 1024,
  parameter int NH = 2,
  parameter int IW = $clog2(SB)
) (
  input  logic [SB-1:0]    bits_i,
  input  logic [NH*IW-1:0] idx_i,
  output logic             hit_o
);
  always_comb begin
    hit_o = 1'b1;
    for (int h = 0; h < NH; h++) begin
      hit_o = hit_o & bits_i[idx_i[h*IW +: IW]];
    end
  end
endmodule

// File: rtl/txsig_phase_fsm.sv
module txsig_phase_fsm
  import txsig_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  txsig_op_e    op_i,
  input  logic         conflict_i,
  output txsig_phase_e phase_o,
  output logic         rd_ins_o,
  output logic         wr_ins_o,
  output logic         rd_clr_o,
  output logic         wr_clr_o
);
  txsig_phase_e phase_d;
  logic         kill;

  assign kill = conflict_i ||
                (op_i == OP_ABORT && (phase_o == PH_ACTIVE || phase_o == PH_COMMIT));

  always_comb begin
    phase_d  = phase_o;
    rd_ins_o = 1'b0;
    wr_ins_o = 1'b0;
    rd_clr_o = 1'b0;
    wr_clr_o = 1'b0;
    if (kill) begin
      phase_d  = PH_IDLE;
      rd_clr_o = 1'b1;
      wr_clr_o = 1'b1;
    end else begin
      case (phase_o)
        PH_IDLE:   if (op_i == OP_BEGIN) phase_d = PH_ACTIVE;
        PH_ACTIVE: begin
          rd_ins_o = (op_i == OP_RD_INS);
          wr_ins_o = (op_i == OP_WR_INS);
          if (op_i == OP_COMMIT) phase_d = PH_COMMIT;
        end
        PH_COMMIT: if (op_i == OP_VALID) begin
          phase_d  = PH_VALID;
          rd_clr_o = 1'b1;
        end
        PH_VALID:  if (op_i == OP_DONE) begin
          phase_d  = PH_IDLE;
          wr_clr_o = 1'b1;
        end
        default:   phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_o <= PH_IDLE;
    else     phase_o <= phase_d;
  end
endmodule

// File: rtl/txsig_snoop_unit.sv
module txsig_snoop_unit
  import txsig_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIG_BITS = 1024,
  parameter int NUM_HASH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              wq_valid,
  input  logic [ADDR_W-1:0] wq_addr,
  output logic              conflict_o,
  output logic              nack_o,
  output logic              wq_hit_o
);
  localparam int IDX_W = $clog2(SIG_BITS);
  localparam int IDXV  = NUM_HASH * IDX_W;

  txsig_op_e     op;
  txsig_phase_e  phase_q;
  logic [IDXV-1:0] cmd_idx, snp_idx, wq_idx;
  logic [SIG_BITS-1:0] rd_bits, wr_bits;
  logic rd_ins, wr_ins, rd_clr, wr_clr;
  logic rd_snp_hit, wr_snp_hit, wr_q_hit;
  logic rd_look, wr_look, conflict_now, nack_now;

  assign op = txsig_op_e'(cmd_op);

  for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
    txsig_hash #(.AW(ADDR_W), .IW(IDX_W), .SEED(h + 1)) u_cmd (
      .addr_i(cmd_addr), .idx_o(cmd_idx[h*IDX_W +: IDX_W]));
    txsig_hash #(.AW(ADDR_W), .IW(IDX_W), .SEED(h + 1)) u_snp (
      .addr_i(snp_addr), .idx_o(snp_idx[h*IDX_W +: IDX_W]));
    txsig_hash #(.AW(ADDR_W), .IW(IDX_W), .SEED(h + 1)) u_wq (
      .addr_i(wq_addr),  .idx_o(wq_idx[h*IDX_W +: IDX_W]));
  end

  txsig_sigvec #(.SB(SIG_BITS), .NH(NUM_HASH), .IW(IDX_W)) u_rd_sig (
    .clk(clk), .rst(rst), .clr_i(rd_clr), .ins_i(rd_ins),
    .ins_idx_i(cmd_idx), .bits_o(rd_bits));

  txsig_sigvec #(.SB(SIG_BITS), .NH(NUM_HASH), .IW(IDX_W)) u_wr_sig (
    .clk(clk), .rst(rst), .clr_i(wr_clr), .ins_i(wr_ins),
    .ins_idx_i(cmd_idx), .bits_o(wr_bits));

  txsig_member #(.SB(SIG_BITS), .NH(NUM_HASH), .IW(IDX_W)) u_rd_snp (
    .bits_i(rd_bits), .idx_i(snp_idx), .hit_o(rd_snp_hit));
  txsig_member #(.SB(SIG_BITS), .NH(NUM_HASH), .IW(IDX_W)) u_wr_snp (
    .bits_i(wr_bits), .idx_i(snp_idx), .hit_o(wr_snp_hit));
  txsig_member #(.SB(SIG_BITS), .NH(NUM_HASH), .IW(IDX_W)) u_wr_qry (
    .bits_i(wr_bits), .idx_i(wq_idx), .hit_o(wr_q_hit));

  // Phase gating of the snoop lookups.
  assign rd_look = snp_valid && snp_excl &&
                   (phase_q == PH_ACTIVE || phase_q == PH_COMMIT);
  assign wr_look = snp_valid && (phase_q == PH_COMMIT || phase_q == PH_VALID);

  assign conflict_now = (rd_look && rd_snp_hit) ||
                        (wr_look && wr_snp_hit && phase_q == PH_COMMIT);
  assign nack_now     = wr_look && wr_snp_hit && phase_q == PH_VALID;

  txsig_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .op_i(op), .conflict_i(conflict_now),
    .phase_o(phase_q), .rd_ins_o(rd_ins), .wr_ins_o(wr_ins),
    .rd_clr_o(rd_clr), .wr_clr_o(wr_clr));

  always_ff @(posedge clk) begin
    if (rst) begin
      conflict_o <= 1'b0;
      nack_o     <= 1'b0;
      wq_hit_o   <= 1'b0;
    end else begin
      conflict_o <= conflict_now;
      nack_o     <= nack_now;
      wq_hit_o   <= wq_valid && wr_q_hit;
    end
  end
endmodule

// File: rtl/txsig_snoop_chk.sv
module txsig_snoop_chk
  import txsig_pkg::*;
#(
  parameter int SB = 1024
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cmd_op,
  input logic          snp_valid,
  input logic          snp_excl,
  input logic          wq_valid,
  input logic          conflict_o,
  input logic          nack_o,
  input logic          wq_hit_o,
  input logic [1:0]    phase,
  input logic [SB-1:0] rd_bits,
  input logic [SB-1:0] wr_bits
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!conflict_o && !nack_o && !wq_hit_o && phase == PH_IDLE));

  p_shared_no_conflict_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACTIVE && snp_valid && !snp_excl) |=> !conflict_o);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |=> (!conflict_o && !nack_o));

  p_empty_query_miss_r4: assert property (@(posedge clk) disable iff (rst)
    (wq_valid && wr_bits == '0) |=> !wq_hit_o);

  p_conflict_clears_r5: assert property (@(posedge clk) disable iff (rst)
    conflict_o |-> (phase == PH_IDLE && rd_bits == '0 && wr_bits == '0));

  p_nack_only_validated_r7: assert property (@(posedge clk) disable iff (rst)
    nack_o |-> ($past(phase) == PH_VALID && $past(snp_valid)));

  p_validated_never_aborts_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_VALID) |=> !conflict_o);

  p_validated_read_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_VALID) |-> (rd_bits == '0));

  p_done_clears_write_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_VALID && cmd_op == 3'(OP_DONE)) |=> (phase == PH_IDLE && wr_bits == '0));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'(OP_ABORT) && (phase == PH_ACTIVE || phase == PH_COMMIT))
    |=> (phase == PH_IDLE && rd_bits == '0 && wr_bits == '0));

  p_abort_ignored_validated_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == 3'(OP_ABORT) && phase == PH_VALID) |=> (phase == PH_VALID));
endmodule

bind txsig_snoop_unit txsig_snoop_chk #(.SB(SIG_BITS)) u_chk (
  .clk(clk), .rst(rst), .cmd_op(cmd_op), .snp_valid(snp_valid),
  .snp_excl(snp_excl), .wq_valid(wq_valid), .conflict_o(conflict_o),
  .nack_o(nack_o), .wq_hit_o(wq_hit_o), .phase(phase_q),
  .rd_bits(rd_bits), .wr_bits(wr_bits));

// File: tb/tb_txsig_snoop_unit.sv
module tb_txsig_snoop_unit;
  localparam int AW = 32;
  localparam logic [2:0] NOP = 3'd0, BEG = 3'd1, RDI = 3'd2, WRI = 3'd3,
                         CMT = 3'd4, VAL = 3'd5, DON = 3'd6, ABT = 3'd7;
  localparam int NROWS = 50;

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] a;
    logic       sv;
    logic       sx;
    logic [1:0] sa;
    logic       qv;
    logic [1:0] qa;
    logic [1:0] ec;
    logic [1:0] en;
    logic [1:0] eq;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(input logic [2:0] op, input logic [1:0] a,
      input logic sv, input logic sx, input logic [1:0] sa,
      input logic qv, input logic [1:0] qa,
      input logic [1:0] ec, input logic [1:0] en, input logic [1:0] eq,
      input logic [3:0] rq);
    vec_t v;
    v = '{op, a, sv, sx, sa, qv, qa, ec, en, eq, rq};
    return v;
  endfunction

  // Address selectors: 0 = A, 1 = B, 2 = C. Expected value 2 = don't care.
  localparam vec_t TBL [NROWS] = '{
    mk(WRI,2,0,0,0,0,0, 0,0,0, 10),  // R10 write entry while idle ignored
    mk(NOP,0,0,0,0,1,2, 0,0,0, 10),  // R10 query C misses
    mk(RDI,1,0,0,0,0,0, 0,0,0, 10),  // R10 read entry while idle ignored
    mk(BEG,0,0,0,0,0,0, 0,0,0, 10),
    mk(NOP,0,1,1,1,0,0, 0,0,0, 10),  // R10 excl B: read sig still empty
    mk(RDI,0,0,0,0,0,0, 0,0,0, 2),
    mk(WRI,2,0,0,0,0,0, 0,0,0, 4),
    mk(NOP,0,1,0,0,0,0, 0,0,0, 3),   // R3 shared A in active
    mk(NOP,0,1,0,2,0,0, 0,0,0, 6),   // R6 shared C, write lookups off in active
    mk(NOP,0,1,1,0,1,2, 1,0,1, 2),   // R2 excl A conflicts; R4 query C hits
    mk(NOP,0,1,1,0,1,2, 0,0,0, 5),   // R5 cleared after conflict
    mk(BEG,0,0,0,0,0,0, 0,0,0, 6),
    mk(RDI,0,0,0,0,0,0, 0,0,0, 6),
    mk(WRI,2,0,0,0,0,0, 0,0,0, 6),
    mk(WRI,1,0,0,0,0,0, 0,0,0, 6),
    mk(CMT,0,0,0,0,0,0, 0,0,0, 6),
    mk(NOP,0,1,0,2,0,0, 1,0,0, 6),   // R6 shared C hits write sig in commit
    mk(BEG,0,0,0,0,0,0, 0,0,0, 6),
    mk(RDI,0,0,0,0,0,0, 0,0,0, 6),
    mk(WRI,2,0,0,0,0,0, 0,0,0, 6),
    mk(CMT,0,0,0,0,0,0, 0,0,0, 6),
    mk(NOP,0,1,1,0,0,0, 1,0,0, 6),   // R6 excl A hits read sig in commit
    mk(BEG,0,0,0,0,0,0, 0,0,0, 7),
    mk(RDI,0,0,0,0,0,0, 0,0,0, 7),
    mk(WRI,2,0,0,0,0,0, 0,0,0, 7),
    mk(CMT,0,0,0,0,0,0, 0,0,0, 7),
    mk(WRI,1,0,0,0,0,0, 0,0,0, 10),  // R10 entry in commit ignored
    mk(VAL,0,0,0,0,0,0, 0,0,0, 7),
    mk(NOP,0,1,0,2,0,0, 0,1,0, 7),   // R7 shared C refused
    mk(NOP,0,1,1,2,0,0, 0,1,0, 7),   // R7 excl C refused, no abort
    mk(NOP,0,1,1,0,0,0, 0,2,0, 7),   // R7 read sig cleared: no conflict
    mk(ABT,0,1,1,2,0,0, 0,1,0, 9),   // R9 abort ignored when validated
    mk(NOP,0,1,0,2,0,0, 0,1,0, 9),   // R9 still refusing
    mk(DON,0,1,0,2,0,0, 0,1,0, 8),
    mk(NOP,0,1,0,2,1,2, 0,0,0, 8),   // R8 write sig cleared, NACK off
    mk(BEG,0,0,0,0,0,0, 0,0,0, 9),
    mk(WRI,1,0,0,0,0,0, 0,0,0, 9),
    mk(RDI,0,0,0,0,0,0, 0,0,0, 9),
    mk(CMT,0,0,0,0,0,0, 0,0,0, 9),
    mk(ABT,0,0,0,0,0,0, 0,0,0, 9),   // R9 abort: no conflict pulse
    mk(NOP,0,1,1,0,1,1, 0,0,0, 9),   // R9 both signatures empty
    mk(BEG,0,0,0,0,0,0, 0,0,0, 10),
    mk(RDI,0,0,0,0,0,0, 0,0,0, 10),
    mk(VAL,0,0,0,0,0,0, 0,0,0, 10),  // R10 validated ignored in active
    mk(NOP,0,1,1,0,0,0, 1,0,0, 10),  // R10 read sig still live
    mk(BEG,0,0,0,0,0,0, 0,0,0, 5),
    mk(WRI,2,0,0,0,0,0, 0,0,0, 5),
    mk(CMT,0,0,0,0,0,0, 0,0,0, 5),
    mk(VAL,0,1,0,2,0,0, 1,0,0, 5),   // R5 conflict beats same-cycle validate
    mk(NOP,0,1,0,2,0,0, 0,0,0, 5)    // R5 idle, nothing refused
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cmd_op = NOP;
  logic [AW-1:0] cmd_addr = '0;
  logic          snp_valid = 1'b0;
  logic          snp_excl = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          wq_valid = 1'b0;
  logic [AW-1:0] wq_addr = '0;
  logic          conflict_o, nack_o, wq_hit_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  txsig_snoop_unit dut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .wq_valid(wq_valid), .wq_addr(wq_addr),
    .conflict_o(conflict_o), .nack_o(nack_o), .wq_hit_o(wq_hit_o));

  function automatic logic [AW-1:0] sel_addr(input logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_1000;
      2'd1:    return 32'h0000_2040;
      default: return 32'h0003_3F08;
    endcase
  endfunction

  task automatic chk(input string what, input int req, input logic got, input logic [1:0] exp);
    if (exp != 2'd2) begin
      n_chk++;
      if (got !== exp[0]) begin
        n_fail++;
        $display("FAIL R%0d %s: got %0b expected %0b", req, what, got, exp[0]);
      end
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next fall.
  task automatic step(input logic [2:0] op, input logic [AW-1:0] a,
                      input logic sv, input logic sx, input logic [AW-1:0] sa,
                      input logic qv, input logic [AW-1:0] qa);
    cmd_op = op; cmd_addr = a; snp_valid = sv; snp_excl = sx; snp_addr = sa;
    wq_valid = qv; wq_addr = qa;
    @(posedge clk);
    @(negedge clk);
    cmd_op = NOP; snp_valid = 1'b0; wq_valid = 1'b0;
  endtask

  function automatic logic [AW-1:0] bulk_addr(input int i);
    return AW'(i * 1237 + 96) << 2;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("reset conflict", 1, conflict_o, 2'd0);
    chk("reset nack", 1, nack_o, 2'd0);
    step(NOP, '0, 0, 0, '0, 1, sel_addr(2));
    chk("reset query", 1, wq_hit_o, 2'd0);

    for (int r = 0; r < NROWS; r++) begin
      step(TBL[r].op, sel_addr(TBL[r].a), TBL[r].sv, TBL[r].sx,
           sel_addr(TBL[r].sa), TBL[r].qv, sel_addr(TBL[r].qa));
      chk($sformatf("row %0d conflict", r), int'(TBL[r].rq), conflict_o, TBL[r].ec);
      chk($sformatf("row %0d nack", r),     int'(TBL[r].rq), nack_o,     TBL[r].en);
      chk($sformatf("row %0d query", r),    int'(TBL[r].rq), wq_hit_o,   TBL[r].eq);
    end

    // R4 no false negatives over many write entries
    step(BEG, '0, 0, 0, '0, 0, '0);
    for (int i = 0; i < 24; i++) step(WRI, bulk_addr(i), 0, 0, '0, 0, '0);
    for (int i = 0; i < 24; i++) begin
      step(NOP, '0, 0, 0, '0, 1, bulk_addr(i));
      chk($sformatf("bulk write query %0d", i), 4, wq_hit_o, 2'd1);
    end
    step(ABT, '0, 0, 0, '0, 0, '0);

    // R2 no false negatives over many read entries
    for (int k = 0; k < 12; k++) begin
      step(BEG, '0, 0, 0, '0, 0, '0);
      for (int i = 0; i < 12; i++) step(RDI, bulk_addr(i + 40), 0, 0, '0, 0, '0);
      step(NOP, '0, 1, 1, bulk_addr(k + 40), 0, '0);
      chk($sformatf("bulk read snoop %0d", k), 2, conflict_o, 2'd1);
    end

    // R1 reset in the middle of a validated commit
    step(BEG, '0, 0, 0, '0, 0, '0);
    step(WRI, sel_addr(2), 0, 0, '0, 0, '0);
    step(CMT, '0, 0, 0, '0, 0, '0);
    step(VAL, '0, 0, 0, '0, 0, '0);
    rst = 1'b1;
    step(NOP, '0, 1, 0, sel_addr(2), 0, '0);
    rst = 1'b0;
    chk("reset mid-commit nack", 1, nack_o, 2'd0);
    step(NOP, '0, 1, 0, sel_addr(2), 1, sel_addr(2));
    chk("post-reset nack", 1, nack_o, 2'd0);
    chk("post-reset query", 1, wq_hit_o, 2'd0);
    chk("post-reset conflict", 1, conflict_o, 2'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule